// File: doc/BRIEF.md
# Converter Power-State Sequencer

This block sits between a sampling host and a successive-approximation converter and owns the converter's two low-power control lines. The host asks for a power state with two request lines, says which reference source is in use, and may enable an automatic doze after every conversion. The sequencer raises the doze line (`nap_o`) or the deep-sleep line (`stby_o`). It then holds back convert-start requests until the wake-up time for the state being left has passed, because a conversion started earlier gives invalid data.

Three wake-up delays are parameters counted in clock cycles: one for leaving doze, one for leaving deep sleep with the on-chip reference, and one for leaving deep sleep when an off-chip reference stayed powered. Doze is never used together with the on-chip reference. A request for it in that case is refused and flagged. A convert request that arrives while the converter is asleep, waking or busy is held in a single slot. A further request while that slot is full is dropped and flagged. A granted conversion occupies the converter for a fixed number of cycles.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is applied and in the first cycle after the synchronised reset is released, `nap_o`, `stby_o`, `cnv_go` and `err_o` are all 0, and the converter is awake and idle.
- R2: From awake and idle, with `ref_int`=0, holding `req_nap`=1 and `req_stby`=0 sets `nap_o` at the next clock edge. `nap_o` and `stby_o` are never high together. A doze request made during a conversion takes effect at the edge after the conversion's last busy cycle.
- R3: When `req_stby`=1, `stby_o` rises at the next edge from awake-idle or from doze, whatever `req_nap` is.
- R4: When `req_nap`=1, `req_stby`=0 and `ref_int`=1, `err_o` is 1 in the next cycle and `nap_o` stays 0. The same holds when `auto_nap`=1 with `ref_int`=1, and then no doze follows a conversion. If `ref_int` rises while dozing, `nap_o` falls at the next edge.
- R5: After `nap_o` falls, `cnv_go` stays low for NAP_WAKE_CYC cycles. A request queued during doze is granted exactly NAP_WAKE_CYC+1 edges after the edge at which `nap_o` fell.
- R6: The same rule as R5 applies to leaving deep sleep with `ref_int`=1 at the leaving edge, using STBY_INT_WAKE_CYC.
- R7: The same rule as R5 applies to leaving deep sleep with `ref_int`=0 at the leaving edge, using STBY_EXT_WAKE_CYC.
- R8: From awake and idle, a one-cycle `cnv_req` gives a one-cycle `cnv_go` at the next edge. The conversion is busy for CONV_CYC cycles starting with the `cnv_go` cycle. A request made during that time is granted CONV_CYC+1 edges after the previous grant.
- R9: A request that arrives while one is already queued and none is granted that cycle is dropped. `err_o` is 1 in the next cycle, and the dropped request never produces a `cnv_go`.
- R10: With `auto_nap`=1 and `ref_int`=0, `nap_o` rises at the edge after each conversion's last busy cycle. A queued request wakes the converter, so one request per grant gives grants spaced CONV_CYC+NAP_WAKE_CYC+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_nap | input | 1 | Request doze state |
| req_stby | input | 1 | Request deep-sleep state (wins over req_nap) |
| ref_int | input | 1 | 1: on-chip reference in use, 0: off-chip reference |
| auto_nap | input | 1 | Doze automatically after each conversion |
| cnv_req | input | 1 | Convert request from the host, one per cycle high |
| nap_o | output | 1 | Doze control line to the converter |
| stby_o | output | 1 | Deep-sleep control line to the converter |
| cnv_go | output | 1 | Convert permit, a one-cycle pulse per conversion |
| err_o | output | 1 | One cycle per refused doze or dropped request |

## Verification
The bench builds the sequencer with NAP_WAKE_CYC=3, STBY_INT_WAKE_CYC=7, STBY_EXT_WAKE_CYC=5 and CONV_CYC=4. At these sizes every wake path and the busy window span only a few cycles. The bench can therefore sweep all eight combinations of the two power requests and the reference flag, and measure each grant latency as an exact cycle count worked out from the parameters. The three distinct delays make a wrong choice of delay show up as a wrong count, and the short busy window lets the single-slot overflow and the automatic-doze cadence be reached within a few tens of cycles.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [2:0] {
    PS_RUN  = 3'd0,
    PS_CONV = 3'd1,
    PS_NAP  = 3'd2,
    PS_STBY = 3'd3,
    PS_WAKE = 3'd4
  } pwr_state_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adc_pwr_rst_sync.sv
module adc_pwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= '0;
    else        sq <= {sq[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sq[STAGES-1];
endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_pwr_req_slot.sv
module adc_pwr_req_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic cnv_req,
  input  logic grant,
  output logic avail,
  output logic overflow
);
  logic pend_q, pend_d;

  always_comb begin
    avail = pend_q | cnv_req;
    if (grant) begin
      // the grant takes the older request; a new one takes the slot
      pend_d   = pend_q & cnv_req;
      overflow = 1'b0;
    end else begin
      pend_d   = pend_q | cnv_req;
      overflow = pend_q & cnv_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int unsigned NAP_WAKE_CYC      = 30,
  parameter int unsigned STBY_INT_WAKE_CYC = 50_000_000,
  parameter int unsigned STBY_EXT_WAKE_CYC = 8_000,
  parameter int unsigned CONV_CYC          = 30,
  parameter int unsigned TW                = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_nap,
  input  logic          req_stby,
  input  logic          ref_int,
  input  logic          auto_nap,
  input  logic          avail,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          grant,
  output logic          go_q,
  output pwr_state_e    st_q
);
  localparam logic [TW-1:0] NAP_LD  = TW'(NAP_WAKE_CYC - 1);
  localparam logic [TW-1:0] SINT_LD = TW'(STBY_INT_WAKE_CYC - 1);
  localparam logic [TW-1:0] SEXT_LD = TW'(STBY_EXT_WAKE_CYC - 1);
  localparam logic [TW-1:0] CONV_LD = TW'(CONV_CYC - 1);

  pwr_state_e st_d;
  logic       nap_ok;
  logic       nap_hold;

  always_comb begin
    nap_ok   = ~ref_int;
    nap_hold = nap_ok & (req_nap | (auto_nap & ~avail));
  end

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    grant    = 1'b0;
    unique case (st_q)
      PS_RUN: begin
        if (req_stby)                st_d = PS_STBY;
        else if (req_nap && nap_ok)  st_d = PS_NAP;
        else if (avail) begin
          grant    = 1'b1;
          st_d     = PS_CONV;
          tmr_load = 1'b1;
          tmr_val  = CONV_LD;
        end
      end
      PS_CONV: begin
        if (tmr_zero) begin
          if (req_stby)                           st_d = PS_STBY;
          else if (nap_ok && (req_nap || auto_nap)) st_d = PS_NAP;
          else                                    st_d = PS_RUN;
        end
      end
      PS_NAP: begin
        if (req_stby) st_d = PS_STBY;
        else if (!nap_hold) begin
          st_d     = PS_WAKE;
          tmr_load = 1'b1;
          tmr_val  = NAP_LD;
        end
      end
      PS_STBY: begin
        if (!req_stby) begin
          st_d     = PS_WAKE;
          tmr_load = 1'b1;
          tmr_val  = ref_int ? SINT_LD : SEXT_LD;
        end
      end
      PS_WAKE: begin
        if (req_stby)      st_d = PS_STBY;
        else if (tmr_zero) st_d = PS_RUN;
      end
      default: st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_RUN;
      go_q <= 1'b0;
    end else begin
      st_q <= st_d;
      go_q <= grant;
    end
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int unsigned NAP_WAKE_CYC      = 30,
  parameter int unsigned STBY_INT_WAKE_CYC = 50_000_000,
  parameter int unsigned STBY_EXT_WAKE_CYC = 8_000,
  parameter int unsigned CONV_CYC          = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_nap,
  input  logic req_stby,
  input  logic ref_int,
  input  logic auto_nap,
  input  logic cnv_req,
  output logic nap_o,
  output logic stby_o,
  output logic cnv_go,
  output logic err_o
);
  localparam int unsigned MAXD = max4(NAP_WAKE_CYC, STBY_INT_WAKE_CYC,
                                      STBY_EXT_WAKE_CYC, CONV_CYC);
  localparam int unsigned TW   = (MAXD < 2) ? 1 : $clog2(MAXD);

  logic          rst_n_i;
  logic          avail, overflow, grant;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  pwr_state_e    st_q;
  logic          err_q, err_d;
  logic          nap_refused;

  adc_pwr_rst_sync #(.STAGES(2)) rsync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  adc_pwr_req_slot slot_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .cnv_req  (cnv_req),
    .grant    (grant),
    .avail    (avail),
    .overflow (overflow)
  );

  adc_pwr_timer #(.TW(TW)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  adc_pwr_fsm #(
    .NAP_WAKE_CYC      (NAP_WAKE_CYC),
    .STBY_INT_WAKE_CYC (STBY_INT_WAKE_CYC),
    .STBY_EXT_WAKE_CYC (STBY_EXT_WAKE_CYC),
    .CONV_CYC          (CONV_CYC),
    .TW                (TW)
  ) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .req_nap  (req_nap),
    .req_stby (req_stby),
    .ref_int  (ref_int),
    .auto_nap (auto_nap),
    .avail    (avail),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .grant    (grant),
    .go_q     (cnv_go),
    .st_q     (st_q)
  );

  always_comb begin
    nap_refused = ref_int & ~req_stby & (req_nap | auto_nap);
    err_d       = nap_refused | overflow;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign err_o  = err_q;
  assign nap_o  = (st_q == PS_NAP);
  assign stby_o = (st_q == PS_STBY);
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk
  import adc_pwr_pkg::*;
#(
  parameter int unsigned NAP_WAKE_CYC      = 30,
  parameter int unsigned STBY_INT_WAKE_CYC = 50_000_000,
  parameter int unsigned STBY_EXT_WAKE_CYC = 8_000,
  parameter int unsigned CONV_CYC          = 30
) (
  input logic clk,
  input logic rst_n,
  input logic req_nap,
  input logic req_stby,
  input logic ref_int,
  input logic nap_o,
  input logic stby_o,
  input logic cnv_go,
  input logic err_o
);
  localparam int unsigned MAXD = max4(NAP_WAKE_CYC, STBY_INT_WAKE_CYC,
                                      STBY_EXT_WAKE_CYC, CONV_CYC);
  localparam int unsigned CW   = $clog2(MAXD + 2) + 1;

  logic [CW-1:0] since;
  logic [CW-1:0] need;
  logic          left_stby, ref_snap, slept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since     <= '0;
      left_stby <= 1'b0;
      ref_snap  <= 1'b0;
      slept     <= 1'b0;
    end else if (stby_o) begin
      since     <= '0;
      left_stby <= 1'b1;
      ref_snap  <= ref_int;
      slept     <= 1'b1;
    end else if (nap_o) begin
      since     <= '0;
      left_stby <= 1'b0;
      slept     <= 1'b1;
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  always_comb begin
    if (!left_stby)    need = CW'(NAP_WAKE_CYC);
    else if (ref_snap) need = CW'(STBY_INT_WAKE_CYC);
    else               need = CW'(STBY_EXT_WAKE_CYC);
  end

  // R2
  excl_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nap_o && stby_o));

  // R5 R6 R7
  wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_go && slept) |-> (since > need));

  // R8
  go_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_go |-> (!nap_o && !stby_o));

  // R8
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_go |=> !cnv_go);

  // R4
  nap_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nap_o) |-> !$past(ref_int));

  // R4
  nap_refuse_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_nap && !req_stby && ref_int) |=> err_o);

  // R3
  stby_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nap_o && req_stby) |=> stby_o);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(
  .NAP_WAKE_CYC      (NAP_WAKE_CYC),
  .STBY_INT_WAKE_CYC (STBY_INT_WAKE_CYC),
  .STBY_EXT_WAKE_CYC (STBY_EXT_WAKE_CYC),
  .CONV_CYC          (CONV_CYC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_nap  (req_nap),
  .req_stby (req_stby),
  .ref_int  (ref_int),
  .nap_o    (nap_o),
  .stby_o   (stby_o),
  .cnv_go   (cnv_go),
  .err_o    (err_o)
);

// File: tb/adc_pwr_seq_tb.sv
module adc_pwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DN = 3;
  localparam int DSI = 7;
  localparam int DSE = 5;
  localparam int DC = 4;

  logic clk, rst_n;
  logic req_nap, req_stby, ref_int, auto_nap, cnv_req;
  logic nap_o, stby_o, cnv_go, err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  adc_pwr_seq #(
    .NAP_WAKE_CYC      (DN),
    .STBY_INT_WAKE_CYC (DSI),
    .STBY_EXT_WAKE_CYC (DSE),
    .CONV_CYC          (DC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_nap(req_nap), .req_stby(req_stby),
    .ref_int(ref_int), .auto_nap(auto_nap), .cnv_req(cnv_req),
    .nap_o(nap_o), .stby_o(stby_o), .cnv_go(cnv_go), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wait_go(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!cnv_go && n < 100);
  endtask

  task automatic pulse_wait(output int n);
    cnv_req = 1'b1;
    step();
    cnv_req = 1'b0;
    n = 1;
    while (!cnv_go && n < 100) begin
      step();
      n++;
    end
  endtask

  task automatic settle();
    req_nap = 0; req_stby = 0; auto_nap = 0; cnv_req = 0;
    repeat (20) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    int cnt;
    rst_n = 0; req_nap = 0; req_stby = 0; ref_int = 0; auto_nap = 0; cnv_req = 0;
    repeat (3) step();
    // R1 reset state
    chk("R1 nap_o", nap_o, 0);
    chk("R1 stby_o", stby_o, 0);
    rst_n = 1;
    repeat (3) step();
    chk("R1 cnv_go", cnv_go, 0);
    chk("R1 err_o", err_o, 0);

    // R8 grant from idle, then request during conversion
    pulse_wait(n);
    chk("R8 idle grant latency", n, 1);
    pulse_wait(n);
    chk("R8 grant spacing", n, DC + 1);
    repeat (DC + 2) step();

    // R9 overflow: grant, then two requests while busy
    pulse_wait(n);
    chk("R9 setup grant", n, 1);
    cnv_req = 1;
    step();
    step();
    chk("R9 err on drop", err_o, 1);
    cnv_req = 0;
    step();
    chk("R9 err clears", err_o, 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (cnv_go) cnt++;
      step();
    end
    chk("R9 one grant only", cnt, 1);
    settle();

    // R2 R3 R4 sweep over power requests and reference flag
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 4; c++) begin
        int en_nap, en_stby, en_err;
        ref_int  = r[0];
        req_nap  = c[0];
        req_stby = c[1];
        en_stby  = c[1];
        en_nap   = c[0] & ~c[1] & ~r;
        en_err   = c[0] & ~c[1] & r;
        step();
        chk($sformatf("R3 stby_o ref=%0d req=%0d", r, c), stby_o, en_stby);
        chk($sformatf("R2 nap_o ref=%0d req=%0d", r, c), nap_o, en_nap);
        chk($sformatf("R4 err_o ref=%0d req=%0d", r, c), err_o, en_err);
        settle();
      end
    end
    ref_int = 0;

    // R3 standby while dozing
    req_nap = 1;
    step();
    req_stby = 1;
    step();
    chk("R3 doze to standby", stby_o, 1);
    settle();

    // R4 reference switch while dozing
    req_nap = 1;
    step();
    chk("R4 doze entered", nap_o, 1);
    ref_int = 1;
    step();
    chk("R4 doze left on ref_int", nap_o, 0);
    settle();
    ref_int = 0;

    // R5 R6 R7 wake latency with a queued request
    for (int k = 0; k < 3; k++) begin
      int dly;
      if (k == 0) begin ref_int = 0; req_nap = 1; dly = DN; end
      else if (k == 1) begin ref_int = 1; req_stby = 1; dly = DSI; end
      else begin ref_int = 0; req_stby = 1; dly = DSE; end
      repeat (3) step();
      cnv_req = 1;
      step();
      cnv_req = 0;
      chk($sformatf("R5 no grant asleep k=%0d", k), cnv_go, 0);
      req_nap = 0; req_stby = 0;
      step();
      chk($sformatf("R5 sleep line fell k=%0d", k), nap_o | stby_o, 0);
      n = 1;
      while (!cnv_go && n < 100) begin
        step();
        n++;
      end
      if (k == 0)      chk("R5 doze wake latency", n, DN + 2);
      else if (k == 1) chk("R6 standby int-ref wake latency", n, DSI + 2);
      else             chk("R7 standby ext-ref wake latency", n, DSE + 2);
      settle();
      if (dly < 0) $display("unreachable");
    end
    ref_int = 0;

    // R2 doze request during a conversion is deferred
    pulse_wait(n);
    req_nap = 1;
    repeat (DC - 1) step();
    chk("R2 doze deferred during conversion", nap_o, 0);
    step();
    chk("R2 doze after conversion", nap_o, 1);
    settle();

    // R10 automatic doze cadence
    auto_nap = 1;
    pulse_wait(n);
    chk("R10 first grant", n, 1);
    repeat (DC) step();
    chk("R10 doze after conversion", nap_o, 1);
    for (int i = 0; i < 3; i++) begin
      pulse_wait(n);
      if (i == 0) chk("R10 wake from doze", n, DN + 2);
      else        chk($sformatf("R10 grant spacing %0d", i), n, DC + DN + 2);
    end
    settle();

    // R4 automatic doze suppressed with on-chip reference
    ref_int = 1;
    auto_nap = 1;
    step();
    chk("R4 auto doze refused err", err_o, 1);
    pulse_wait(n);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      if (nap_o) cnt++;
      step();
    end
    chk("R4 no auto doze with ref_int", cnt, 0);
    settle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule